// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the memory address for each beat of a four-beat burst. Either of two active-low start strobes captures a base address. The block then walks the two least significant address bits through the burst, one step for each clock edge at which the active-low advance input is low. The bits above the two burst bits do not change during a burst.

An order-select input picks how the low bits advance. In linear order they count up modulo four. In interleaved order they are the base bits XORed with the beat number. The order-select input passes through a register, so a change reaches the output one edge later. The processor-side strobe only counts while the primary chip select is asserted, and it wins when both strobes arrive together. The controller-side strobe loads whatever the chip select does.

A status output shows which strobe started the current burst. All state changes on the rising clock edge. The outputs are driven straight from registers, with no combinational path from any input.

Top module: `burst_addr_seq`

## Requirements
- R1: While rstN is low and at the first edge after release, addrOut is 0, burstActive is 0 and procStart is 0.
- R2: A rising edge with ctrlStrobeN low and no winning processor strobe loads addrIn, whatever chipSelN is. After that edge, addrOut equals the loaded address, burstActive is 1 and procStart is 0.
- R3: A rising edge with procStrobeN low and chipSelN low loads addrIn. After that edge, addrOut equals it, burstActive is 1 and procStart is 1.
- R4: When procStrobeN is low, chipSelN is high and ctrlStrobeN is high, the processor strobe is ignored. addrOut, burstActive and procStart keep their values.
- R5: When both strobes are low, the processor strobe wins if chipSelN is low (procStart becomes 1). If chipSelN is high, the controller strobe loads (procStart becomes 0).
- R6: During an active burst with no strobe, an edge with advanceN low moves to the next beat. An edge with advanceN high holds addrOut unchanged.
- R7: With the registered order at 0 (linear), addrOut[1:0] equals (base[1:0] + beat) mod 4.
- R8: With the registered order at 1 (interleaved), addrOut[1:0] equals base[1:0] XOR beat.
- R9: addrOut above bit 1 changes only at an edge that loads.
- R10: The advance after beat 3 returns the low bits to the base value and clears burstActive. Advances while burstActive is 0 leave addrOut unchanged.
- R11: A change on orderSel does not alter addrOut until the next rising edge has registered it.
- R12: A load at the same edge as an asserted advance takes priority, and the burst restarts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | Base address captured on a load |
| procStrobeN | input | 1 | Processor-side burst start, active low, qualified by chipSelN |
| ctrlStrobeN | input | 1 | Controller-side burst start, active low, unqualified |
| advanceN | input | 1 | Step to next beat, active low |
| chipSelN | input | 1 | Primary chip select, active low |
| orderSel | input | 1 | Burst order: 0 linear, 1 interleaved (registered) |
| addrOut | output | ADDR_W | Address of the current beat |
| burstActive | output | 1 | A burst is in progress |
| procStart | output | 1 | Current burst was started by the processor strobe |

## Verification
Every result of a load, an advance or a hold appears one edge after the edge that samples the stimulus. The bench drives inputs 2 ns after a rising edge and reads outputs 2 ns after the following rising edge, so each check lands exactly one register stage after its stimulus. For the order input, the bench changes orderSel mid-cycle and reads addrOut once before the next edge, where it must still show the old order. It reads addrOut again after that edge, where the new order must apply. The four-beat walk and its wrap are checked beat by beat, each one edge after its advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // command strobes from control to datapath
  typedef struct packed {
    logic load;      // capture base, restart beat count
    logic loadProc;  // the load came from the processor strobe
    logic step;      // move to the next beat
  } seqCmd_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advanceN,
  input  logic    chipSelN,
  input  logic    lastBeat,
  output seqCmd_t cmd,
  output logic    burstActive,
  output logic    procStart
);
  logic procLoad;
  logic ctrlLoad;
  logic activeQ;
  logic procQ;

  always_comb begin
    // processor strobe needs the chip select; it has priority
    procLoad     = !procStrobeN && !chipSelN;
    ctrlLoad     = !ctrlStrobeN;
    cmd.load     = procLoad || ctrlLoad;
    cmd.loadProc = procLoad;
    cmd.step     = !cmd.load && !advanceN && activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      procQ   <= 1'b0;
    end else if (cmd.load) begin
      activeQ <= 1'b1;
      procQ   <= cmd.loadProc;
    end else if (cmd.step && lastBeat) begin
      activeQ <= 1'b0;
    end
  end

  assign burstActive = activeQ;
  assign procStart   = procQ;
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              lastBeat
);
  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  logic [UPPER_W-1:0]   upperQ;
  logic [BEAT_BITS-1:0] baseLowQ;
  logic [BEAT_BITS-1:0] beatQ;
  logic                 modeQ;
  logic [BEAT_BITS-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ   <= '0;
      baseLowQ <= '0;
      beatQ    <= '0;
      modeQ    <= 1'b0;
    end else begin
      modeQ <= orderSel;
      if (cmd.load) begin
        upperQ   <= addrIn[ADDR_W-1:BEAT_BITS];
        baseLowQ <= addrIn[BEAT_BITS-1:0];
        beatQ    <= '0;
      end else if (cmd.step) begin
        beatQ <= beatQ + 1'b1;
      end
    end
  end

  always_comb begin
    if (modeQ) lowBits = baseLowQ ^ beatQ;
    else       lowBits = baseLowQ + beatQ;
  end

  assign lastBeat = &beatQ;
  assign addrOut  = {upperQ, lowBits};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipSelN,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              burstActive,
  output logic              procStart
);
  seqCmd_t cmd;
  logic    lastBeat;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipSelN(chipSelN), .lastBeat(lastBeat), .cmd(cmd),
    .burstActive(burstActive), .procStart(procStart)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addrIn(addrIn), .orderSel(orderSel),
    .addrOut(addrOut), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              chipSelN,
  input logic [ADDR_W-1:0] addrOut,
  input logic              burstActive,
  input logic              procStart
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && (procStrobeN || chipSelN)) |=>
      (addrOut == $past(addrIn) && burstActive && !procStart));

  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipSelN) |=> (addrOut == $past(addrIn) && burstActive && procStart));

  // R4
  proc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && chipSelN && ctrlStrobeN && advanceN) |=>
      ($stable(burstActive) && $stable(procStart)));

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((procStrobeN || chipSelN) && ctrlStrobeN) |=>
      $stable(addrOut[ADDR_W-1:BEAT_BITS]));

  // R10
  end_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstActive) |-> $past(!advanceN));
endmodule

bind burst_addr_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipSelN(chipSelN),
  .addrOut(addrOut), .burstActive(burstActive), .procStart(procStart)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 18;
  localparam logic [AW-1:0] BASE_A = 18'h1ABC5; // low bits 01
  localparam logic [AW-1:0] BASE_B = 18'h23456;
  localparam logic [AW-1:0] BASE_C = 18'h3F00B;

  logic clk = 0;
  logic rstN;
  logic [AW-1:0] addrIn;
  logic procStrobeN, ctrlStrobeN, advanceN, chipSelN, orderSel;
  logic [AW-1:0] addrOut;
  logic burstActive, procStart;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_BITS(2)) i_burst_addr_seq (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipSelN(chipSelN),
    .orderSel(orderSel), .addrOut(addrOut), .burstActive(burstActive),
    .procStart(procStart)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1; chipSelN = 1;
  endtask

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, int k, bit inter);
    logic [1:0] lo;
    lo = inter ? (b[1:0] ^ 2'(k)) : 2'(b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  task automatic ctrlLoad(logic [AW-1:0] a);
    ctrlStrobeN = 0; addrIn = a; step(); idle();
  endtask

  task automatic tReset();
    chk("R1 addrOut", addrOut, '0);
    chk("R1 burstActive", AW'(burstActive), '0);
    chk("R1 procStart", AW'(procStart), '0);
  endtask

  task automatic tCtrlLoad();
    chipSelN = 1; ctrlStrobeN = 0; addrIn = BASE_A; step(); idle();
    chk("R2 addr", addrOut, BASE_A);
    chk("R2 active", AW'(burstActive), 1);
    chk("R2 procStart", AW'(procStart), 0);
  endtask

  task automatic tProcLoad();
    procStrobeN = 0; chipSelN = 0; addrIn = BASE_B; step(); idle();
    chk("R3 addr", addrOut, BASE_B);
    chk("R3 procStart", AW'(procStart), 1);
  endtask

  task automatic tProcIgnored();
    procStrobeN = 0; chipSelN = 1; addrIn = BASE_C; step(); idle();
    chk("R4 addr held", addrOut, BASE_B);
    chk("R4 procStart held", AW'(procStart), 1);
  endtask

  task automatic tPriority();
    ctrlLoad(BASE_A);
    procStrobeN = 0; ctrlStrobeN = 0; chipSelN = 0; addrIn = BASE_C; step(); idle();
    chk("R5 proc wins addr", addrOut, BASE_C);
    chk("R5 proc wins flag", AW'(procStart), 1);
    procStrobeN = 0; ctrlStrobeN = 0; chipSelN = 1; addrIn = BASE_B; step(); idle();
    chk("R5 ctrl when deselected addr", addrOut, BASE_B);
    chk("R5 ctrl when deselected flag", AW'(procStart), 0);
  endtask

  task automatic tWalk(bit inter, string tag);
    ctrlLoad(BASE_A);
    chk({tag, " beat0"}, addrOut, expAddr(BASE_A, 0, inter));
    for (int k = 1; k < 4; k++) begin
      advanceN = 0; step(); idle();
      chk({tag, " beat"}, addrOut, expAddr(BASE_A, k, inter));
      chk("R9 upper bits", addrOut >> 2, BASE_A >> 2);
      chk("R6 active during burst", AW'(burstActive), 1);
    end
    step();
    chk("R6 hold without advance", addrOut, expAddr(BASE_A, 3, inter));
    advanceN = 0; step(); idle();
    chk("R10 wrap to base", addrOut, BASE_A);
    chk("R10 active cleared", AW'(burstActive), 0);
    advanceN = 0; step(); step(); idle();
    chk("R10 inactive advance ignored", addrOut, BASE_A);
  endtask

  task automatic tModeLatency();
    orderSel = 0; step();
    ctrlLoad(BASE_A);
    advanceN = 0; step(); idle();
    chk("R11 linear beat1", addrOut, expAddr(BASE_A, 1, 0));
    orderSel = 1; #1;
    chk("R11 before edge", addrOut, expAddr(BASE_A, 1, 0));
    step();
    chk("R11 after edge", addrOut, expAddr(BASE_A, 1, 1));
  endtask

  task automatic tLoadBeatsAdvance();
    ctrlLoad(BASE_A);
    advanceN = 0; step();
    ctrlStrobeN = 0; addrIn = BASE_C; step(); idle();
    chk("R12 load wins", addrOut, BASE_C);
    advanceN = 0; step(); idle();
    chk("R12 next beat from restart", addrOut, expAddr(BASE_C, 1, 1));
  endtask

  initial begin
    rstN = 0; idle(); orderSel = 0; addrIn = '0;
    repeat (3) @(posedge clk);
    #2;
    tReset();
    rstN = 1; step();
    tReset();
    tCtrlLoad();
    tProcLoad();
    tProcIgnored();
    tPriority();
    tWalk(0, "R7 linear");
    orderSel = 1; step();
    tWalk(1, "R8 interleaved");
    tModeLatency();
    tLoadBeatsAdvance();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule